// File: doc/BRIEF.md
# Voice Recorder Control Sequencer

This block is the digital control state machine of a single-chip message recorder. Three active-low control inputs start its cycles: a record request, an edge-triggered play request and a level-triggered play request. An 8-bit address/mode bus is captured at the moment a control input falls. The block drives a record indicator, start and stop strobes for the analog storage path, a strobe that writes the end-of-message marker, and a standby (power-down) flag. A separate address counter does the stepping and reports "storage full" and "end-of-message marker found" back through two status inputs.

The block decides which request wins and when each cycle ends. Record beats playback, both when requests arrive together and when record is requested in the middle of a playback. Level-triggered playback runs only while its input is held low. Edge-triggered playback ignores its input once it has started. Release of the record input is accepted only after the input has stayed high for a set number of sample ticks. A sample tick is the input clock divided by two. Every cycle ends in standby, and only a fresh falling edge starts the next one.

Top module: `voice_ctrl_seq`

## Requirements
- R1: After reset the block is in standby: `pwr_dn_o`=1, `rec_led_n_o`=1, `rec_on_o`=`play_on_o`=0, and no strobe is high.
- R2: A falling edge on any control input in standby captures `bus_i` and pulses `start_o`. The capture and the pulse are visible two clock edges after the input falls, because the input passes through a one-flop synchronizer and a fall detector.
- R3: If captured bits 7 and 6 are both 1, the capture is a mode word: `mode_o`=1, `mode_bits_o` = captured bits 5..0, and `start_addr_o`=0. Otherwise `mode_o`=0, `mode_bits_o`=0, and `start_addr_o` equals the captured byte.
- R4: A level-triggered playback ends with one `stop_o` pulse when its input returns high or when `eom_hit_i` is 1.
- R5: An edge-triggered playback is unaffected by its input rising or falling again, and it ends only on `eom_hit_i` or `cnt_full_i`.
- R6: Record has priority. If record and play fall in the same cycle, record starts. A record fall during playback moves straight to record, with `stop_o` and `start_o` both pulsed in the same cycle. `rec_on_o` and `play_on_o` are never both 1.
- R7: Record ends on release only after the record input has been high for DEB_TICKS+1 consecutive ticks. A shorter high spell resets the count and recording continues.
- R8: Every record exit, whether on release or on `cnt_full_i`, pulses `eom_wr_o` and `stop_o` for one cycle and enters standby.
- R9: `rec_led_n_o` is 0 for the whole record cycle. When playback ends on `eom_hit_i`, it is driven 0 for LED_TICKS ticks.
- R10: The block returns to standby even when a play input is still held low. A held-low input never restarts a cycle, but a new falling edge does.
- R11: `adv_o` is 1 on every sample tick while record or playback is active, and 0 in standby.
- R12: `cnt_full_i` during playback ends it with `stop_o` and without the indicator pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; a sample tick is taken every second cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_n_i | input | 1 | Record request, active low |
| play_edge_n_i | input | 1 | Edge-triggered play request, active low |
| play_lvl_n_i | input | 1 | Level-triggered play request, active low |
| bus_i | input | 8 | Address or mode word |
| cnt_full_i | input | 1 | Address counter reached the end of storage |
| eom_hit_i | input | 1 | End-of-message marker reached during playback |
| rec_on_o | output | 1 | Record path active |
| play_on_o | output | 1 | Playback path active |
| start_o | output | 1 | One-cycle start strobe, load `start_addr_o` |
| stop_o | output | 1 | One-cycle stop strobe |
| eom_wr_o | output | 1 | One-cycle strobe that writes the end-of-message marker |
| adv_o | output | 1 | Counter advance on each active tick |
| pwr_dn_o | output | 1 | Standby / power-down |
| rec_led_n_o | output | 1 | Record indicator, active low |
| mode_o | output | 1 | Captured word is a mode word |
| mode_bits_o | output | 6 | Captured mode bits |
| start_addr_o | output | 8 | Start address for the counter |

## Verification
Two situations are hard to reach from the ports. The first is a record release that bounces: the input goes high for fewer ticks than the debounce length and then low again. The debounce count must restart without a new cycle beginning. The bench reaches this by raising the record input for two cycles in the middle of a recording, and later by holding it high for longer than the window. The second hard case is a play input still held low when the end-of-message marker arrives. The bench keeps the input low through the marker, waits in standby, and then releases and lowers it again to show that only the new edge restarts playback.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REC    = 2'd1,
        ST_PLAY_E = 2'd2,
        ST_PLAY_L = 2'd3
    } vrc_state_e;

    localparam int CTRL_N  = 3;
    localparam int IDX_REC = 0;
    localparam int IDX_PE  = 1;
    localparam int IDX_PL  = 2;
endpackage

// File: rtl/vrc_tick_div.sv
module vrc_tick_div (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic tick_d, tick_q;

    always_comb tick_d = ~tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick_o = tick_q;

    // R11: sample ticks alternate with the input clock
    p_tick_alt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/vrc_in_sync.sv
module vrc_in_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_n,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s;
        logic [W-1:0] p;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s = din_n;
        r_d.p = r_q.s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s: '1, p: '1};
        else        r_q <= r_d;
    end

    assign lvl_o  = r_q.s;
    assign fall_o = r_q.p & ~r_q.s;

    // R2: a detected fall means the raw input was low one cycle earlier
    p_fall_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_o) |-> (($past(din_n) & fall_o) == '0));
endmodule

// File: rtl/voice_ctrl_seq.sv
module voice_ctrl_seq
    import vrc_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int DEB_TICKS = 25600,
    parameter int LED_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_n_i,
    input  logic             play_edge_n_i,
    input  logic             play_lvl_n_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             cnt_full_i,
    input  logic             eom_hit_i,
    output logic             rec_on_o,
    output logic             play_on_o,
    output logic             start_o,
    output logic             stop_o,
    output logic             eom_wr_o,
    output logic             adv_o,
    output logic             pwr_dn_o,
    output logic             rec_led_n_o,
    output logic             mode_o,
    output logic [BUS_W-3:0] mode_bits_o,
    output logic [BUS_W-1:0] start_addr_o
);
    localparam int DEB_W = $clog2(DEB_TICKS + 1) < 1 ? 1 : $clog2(DEB_TICKS + 1);
    localparam int LED_W = $clog2(LED_TICKS + 1) < 1 ? 1 : $clog2(LED_TICKS + 1);
    localparam logic [DEB_W-1:0] DEB_LIM = DEB_W'(DEB_TICKS);
    localparam logic [LED_W-1:0] LED_LEN = LED_W'(LED_TICKS);

    typedef struct packed {
        vrc_state_e       state;
        logic [BUS_W-1:0] latch;
        logic [DEB_W-1:0] deb;
        logic [LED_W-1:0] led;
        logic             start;
        logic             stop;
        logic             eomw;
    } seq_t;

    logic              tick;
    logic [CTRL_N-1:0] lvl, fall;
    seq_t              r_d, r_q;

    vrc_tick_div u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    vrc_in_sync #(.W(CTRL_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_n ({play_lvl_n_i, play_edge_n_i, rec_n_i}),
        .lvl_o (lvl),
        .fall_o(fall)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.stop  = 1'b0;
        r_d.eomw  = 1'b0;
        if (r_q.led != '0 && tick) r_d.led = r_q.led - 1'b1;

        unique case (r_q.state)
            ST_IDLE: begin
                if (fall[IDX_REC]) begin
                    r_d.state = ST_REC;
                    r_d.latch = bus_i;
                    r_d.start = 1'b1;
                    r_d.deb   = '0;
                end else if (fall[IDX_PE]) begin
                    r_d.state = ST_PLAY_E;
                    r_d.latch = bus_i;
                    r_d.start = 1'b1;
                end else if (fall[IDX_PL]) begin
                    r_d.state = ST_PLAY_L;
                    r_d.latch = bus_i;
                    r_d.start = 1'b1;
                end
            end
            ST_REC: begin
                if (cnt_full_i) begin
                    r_d.state = ST_IDLE;
                    r_d.stop  = 1'b1;
                    r_d.eomw  = 1'b1;
                end else if (lvl[IDX_REC]) begin
                    if (r_q.deb == DEB_LIM) begin
                        r_d.state = ST_IDLE;
                        r_d.stop  = 1'b1;
                        r_d.eomw  = 1'b1;
                    end else if (tick) begin
                        r_d.deb = r_q.deb + 1'b1;
                    end
                end else begin
                    r_d.deb = '0;
                end
            end
            default: begin
                if (fall[IDX_REC]) begin
                    r_d.state = ST_REC;
                    r_d.latch = bus_i;
                    r_d.start = 1'b1;
                    r_d.stop  = 1'b1;
                    r_d.deb   = '0;
                end else if (eom_hit_i) begin
                    r_d.state = ST_IDLE;
                    r_d.stop  = 1'b1;
                    r_d.led   = LED_LEN;
                end else if (cnt_full_i) begin
                    r_d.state = ST_IDLE;
                    r_d.stop  = 1'b1;
                end else if (r_q.state == ST_PLAY_L && lvl[IDX_PL]) begin
                    r_d.state = ST_IDLE;
                    r_d.stop  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, latch: '0, deb: '0, led: '0,
                     start: 1'b0, stop: 1'b0, eomw: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rec_on_o     = (r_q.state == ST_REC);
    assign play_on_o    = (r_q.state == ST_PLAY_E) || (r_q.state == ST_PLAY_L);
    assign pwr_dn_o     = (r_q.state == ST_IDLE);
    assign start_o      = r_q.start;
    assign stop_o       = r_q.stop;
    assign eom_wr_o     = r_q.eomw;
    assign adv_o        = (r_q.state != ST_IDLE) && tick;
    assign rec_led_n_o  = !rec_on_o && (r_q.led == '0);
    assign mode_o       = r_q.latch[BUS_W-1] & r_q.latch[BUS_W-2];
    assign mode_bits_o  = mode_o ? r_q.latch[BUS_W-3:0] : '0;
    assign start_addr_o = mode_o ? '0 : r_q.latch;

    // R6: never both paths at once
    p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_on_o, play_on_o}));
    // R6: record request aborts playback in one step
    p_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (play_on_o && fall[IDX_REC]) |=> (rec_on_o && start_o && stop_o));
    // R5: edge playback persists without a terminating event
    p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PLAY_E && !fall[IDX_REC] && !eom_hit_i && !cnt_full_i)
        |=> (r_q.state == ST_PLAY_E));
    // R4: level playback stops when its input is back high
    p_level_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PLAY_L && lvl[IDX_PL] && !fall[IDX_REC]) |=> pwr_dn_o);
    // R8: storage full while recording writes the marker and idles
    p_full_eom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_on_o && cnt_full_i) |=> (eom_wr_o && pwr_dn_o));
    // R7: release inside the debounce window keeps recording
    p_deb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_on_o && !cnt_full_i && r_q.deb != DEB_LIM) |=> rec_on_o);
    // R10: standby holds until a new falling edge
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn_o && !(|fall)) |=> (pwr_dn_o && !start_o));
endmodule

// File: tb/voice_ctrl_seq_tb.sv
module voice_ctrl_seq_tb;
    localparam int DEB = 5;
    localparam int LEDT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_n = 1'b1, pe_n = 1'b1, pl_n = 1'b1;
    logic [7:0] bus = 8'h00;
    logic full = 1'b0, eom = 1'b0;
    logic rec_on, play_on, start, stop, eomw, adv, pwr_dn, led_n, mode;
    logic [5:0] mbits;
    logic [7:0] saddr;

    int total = 0, bad = 0, cyc = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    voice_ctrl_seq #(.BUS_W(8), .DEB_TICKS(DEB), .LED_TICKS(LEDT)) u_dut (
        .clk(clk), .rst_n(rst_n), .rec_n_i(rec_n), .play_edge_n_i(pe_n),
        .play_lvl_n_i(pl_n), .bus_i(bus), .cnt_full_i(full), .eom_hit_i(eom),
        .rec_on_o(rec_on), .play_on_o(play_on), .start_o(start), .stop_o(stop),
        .eom_wr_o(eomw), .adv_o(adv), .pwr_dn_o(pwr_dn), .rec_led_n_o(led_n),
        .mode_o(mode), .mode_bits_o(mbits), .start_addr_o(saddr));

    // behavioural reference: 0 idle, 1 record, 2 edge play, 3 level play
    int m_state, m_deb, m_led;
    bit m_tick, m_start, m_stop, m_eomw;
    bit s_rec, s_pe, s_pl, p_rec, p_pe, p_pl;
    logic [7:0] m_bus;
    int cnt_dut_start = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_deb = 0; m_led = 0; m_tick = 0;
            m_start = 0; m_stop = 0; m_eomw = 0; m_bus = 0;
            s_rec = 1; s_pe = 1; s_pl = 1; p_rec = 1; p_pe = 1; p_pl = 1;
        end else begin
            bit fr, fe, fl;
            int ns, nd, nl;
            fr = p_rec && !s_rec; fe = p_pe && !s_pe; fl = p_pl && !s_pl;
            ns = m_state; nd = m_deb; nl = m_led;
            m_start = 0; m_stop = 0; m_eomw = 0;
            if (m_led > 0 && m_tick) nl = m_led - 1;
            if (m_state == 0) begin
                if (fr || fe || fl) begin
                    ns = fr ? 1 : (fe ? 2 : 3);
                    m_bus = bus; m_start = 1; nd = 0;
                end
            end else if (m_state == 1) begin
                if (full || (s_rec && m_deb == DEB)) begin
                    ns = 0; m_stop = 1; m_eomw = 1;
                end else if (s_rec) begin
                    if (m_tick) nd = m_deb + 1;
                end else nd = 0;
            end else begin
                if (fr) begin ns = 1; m_bus = bus; m_start = 1; m_stop = 1; nd = 0; end
                else if (eom) begin ns = 0; m_stop = 1; nl = LEDT; end
                else if (full) begin ns = 0; m_stop = 1; end
                else if (m_state == 3 && s_pl) begin ns = 0; m_stop = 1; end
            end
            m_state = ns; m_deb = nd; m_led = nl;
            p_rec = s_rec; p_pe = s_pe; p_pl = s_pl;
            s_rec = rec_n; s_pe = pe_n; s_pl = pl_n;
            m_tick = !m_tick;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference (R9 indicator, R11 advance inside)
    always @(negedge clk) begin
        if (rst_n) begin
            bit mm;
            mm = m_bus[7] & m_bus[6];
            chk(cur_req, "rec_on", rec_on, m_state == 1);
            chk(cur_req, "play_on", play_on, m_state >= 2);
            chk(cur_req, "pwr_dn", pwr_dn, m_state == 0);
            chk(cur_req, "start", start, m_start);
            chk(cur_req, "stop", stop, m_stop);
            chk(cur_req, "eom_wr", eomw, m_eomw);
            chk("R11", "adv", adv, (m_state != 0) && m_tick);
            chk("R9", "led_n", led_n, (m_state != 1) && (m_led == 0));
            chk("R3", "mode", mode, mm);
            chk("R3", "mode_bits", mbits, mm ? m_bus[5:0] : 0);
            chk("R3", "start_addr", saddr, mm ? 0 : m_bus);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_eom();
        @(negedge clk); eom = 1'b1; @(negedge clk); eom = 1'b0;
    endtask

    task automatic pulse_full();
        @(negedge clk); full = 1'b1; @(negedge clk); full = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(3);
        chk("R1", "pwr_dn", pwr_dn, 1);
        chk("R1", "led_n", led_n, 1);
        chk("R1", "start", start, 0);

        // R2/R4: level play with plain address, stop on release
        cur_req = "R2";
        bus = 8'h25; pl_n = 1'b0;
        step(2);
        chk("R2", "start", start, 1);
        chk("R2", "start_addr", saddr, 8'h25);
        cur_req = "R4";
        step(6);
        pl_n = 1'b1;
        step(4);
        chk("R4", "pwr_dn", pwr_dn, 1);
        // R4: level play stops on marker while held
        pl_n = 1'b0; bus = 8'h10;
        step(4);
        pulse_eom();
        step(1);
        chk("R4", "pwr_dn", pwr_dn, 1);
        chk("R9", "led_n", led_n, 0);
        step(6);
        pl_n = 1'b1;
        step(3);

        // R5: edge play ignores release and re-fall
        cur_req = "R5";
        bus = 8'h40; pe_n = 1'b0;
        step(3); pe_n = 1'b1;
        step(5); pe_n = 1'b0;
        step(3); pe_n = 1'b1;
        step(5);
        chk("R5", "play_on", play_on, 1);
        pulse_eom();
        step(8);

        // R3/R6: simultaneous record and play, mode word
        cur_req = "R6";
        bus = 8'hC5; rec_n = 1'b0; pe_n = 1'b0;
        step(3);
        chk("R6", "rec_on", rec_on, 1);
        chk("R3", "mode", mode, 1);
        chk("R3", "mode_bits", mbits, 5);
        chk("R3", "start_addr", saddr, 0);
        pe_n = 1'b1;
        // R7: short release glitch keeps recording
        cur_req = "R7";
        step(4); rec_n = 1'b1; step(2); rec_n = 1'b0;
        step(6);
        chk("R7", "rec_on", rec_on, 1);
        rec_n = 1'b1;
        step(8);
        chk("R7", "rec_on", rec_on, 1);
        step(12);
        chk("R8", "pwr_dn", pwr_dn, 1);

        // R6: record pre-empts a level playback
        cur_req = "R6";
        bus = 8'h33; pl_n = 1'b0;
        step(5);
        bus = 8'h07; rec_n = 1'b0;
        step(2);
        chk("R6", "stop", stop, 1);
        chk("R6", "start", start, 1);
        chk("R6", "start_addr", saddr, 8'h07);
        pl_n = 1'b1;
        // R8: storage full while recording
        cur_req = "R8";
        step(5);
        pulse_full();
        chk("R8", "eom_wr", eomw, 1);
        step(6);
        chk("R8", "pwr_dn", pwr_dn, 1);
        rec_n = 1'b1;
        step(20);

        // R10: play held low through marker, then bounce restarts
        cur_req = "R10";
        bus = 8'h11; pe_n = 1'b0;
        step(4);
        pulse_eom();
        step(10);
        chk("R10", "pwr_dn", pwr_dn, 1);
        pe_n = 1'b1; step(1); pe_n = 1'b0;
        step(3);
        chk("R10", "play_on", play_on, 1);
        // R12: overflow in play, no indicator pulse
        cur_req = "R12";
        pulse_full();
        step(1);
        chk("R12", "led_n", led_n, 1);
        chk("R12", "pwr_dn", pwr_dn, 1);
        pe_n = 1'b1;
        step(6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule